// File: doc/BRIEF.md
# Mode-Selected Four-Operand Arithmetic Sequencer

This block evaluates one of two signed-pattern sums of four 8-bit operands. It uses one accumulator register and one shared add/subtract unit, and steps through the operands over a fixed run of clock cycles. A `mode` input chooses the sign pattern. With `mode` low the block produces a + b + c - d. With `mode` high it produces a - b + c + d. Every result wraps modulo 2^WIDTH, and no overflow is flagged.

A caller drives the four operands and `mode`, then raises `go`. The block accepts a request only when it is idle or finished, and only when `go` has been seen low since the previous request was taken. A level held over several cycles therefore starts exactly one computation. While the sequence runs, `finished` is low and `result` shows each partial sum. The sequence then stops with `finished` high and `result` frozen. It stays that way until a new request is accepted or the asynchronous reset is applied.

Top module: `mode_arith_seq`

## Requirements
- R1: With `mode` = 0 when a request is accepted, the final `result` equals (a + b + c - d) mod 256.
- R2: With `mode` = 1 when a request is accepted, the final `result` equals (a - b + c + d) mod 256.
- R3: Suppose `go` is sampled high at a rising edge while the block is idle or finished, and `go` has been low since the last acceptance. Then `finished` is high after the fifth rising edge, counting that accepting edge as the first.
- R4: `finished` is low after each of the four rising edges that follow an accepting edge.
- R5: Holding `go` high across two consecutive rising edges launches a single computation only.
- R6: If `go` stays high continuously after a computation ends, no new computation starts. Before the next acceptance, `go` must be sampled low at a rising edge and then high again.
- R7: `mode` is captured at the accepting edge. Changing `mode` during the busy cycles does not alter the result.
- R8: Driving `rst_n` low clears `result` to 0 and `finished` to 0 immediately, without waiting for a clock edge and even in the middle of a sequence. It also returns the block to idle.
- R9: While `finished` is high and no request is accepted, `result` stays constant even when a, b, c or d change.
- R10: The partial sums appear on `result` in a fixed order. After the second edge `result` = a. After the third it is a + b (mode 0) or a - b (mode 1). After the fourth, c has been added to that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Request to start a computation (level, re-armed by a low sample) |
| mode | input | 1 | Sign pattern select: 0 = +b, -d; 1 = -b, +d |
| a | input | 8 | First operand, loaded into the accumulator |
| b | input | 8 | Second operand |
| c | input | 8 | Third operand, always added |
| d | input | 8 | Fourth operand |
| result | output | 8 | Accumulator contents |
| finished | output | 1 | High while the completed result is being held |

## Verification
Counting the accepting edge as edge one, the accumulator shows a after edge two, the b term after edge three and the c term after edge four. The final value and a high `finished` arrive after edge five. The bench drives every input on the falling edge and reads each of these values on the falling edge that follows the edge that produces it. It flips `mode` right after acceptance and expects the originally selected pattern. Hold and re-arm checks run for a fixed number of cycles after `finished` rises. The reset check samples one nanosecond after `rst_n` falls, with no clock edge in between.

// File: rtl/mas_pkg.sv
package mas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_TERM_B,
    ST_TERM_C,
    ST_TERM_D,
    ST_HOLD
  } seq_state_e;

  typedef enum logic [1:0] {
    PICK_B = 2'd0,
    PICK_C = 2'd1,
    PICK_D = 2'd2
  } opnd_pick_e;

  typedef struct packed {
    logic       acc_we;
    logic       take_a;
    opnd_pick_e pick;
    logic       subtract;
  } ctl_vec_t;

endpackage

// File: rtl/mas_arm.sv
module mas_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic accept,
  output logic armed
);

  logic armed_q;

  // Re-arms whenever go is sampled low; disarms on an accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else begin
      armed_q <= ~go | (armed_q & ~accept);
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/mas_ctrl.sv
module mas_ctrl
  import mas_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  logic     mode,
  input  logic     armed,
  output ctl_vec_t ctl,
  output logic     accept,
  output logic     busy,
  output logic     finished
);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       mode_q;
  logic       can_take;

  assign can_take = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign accept   = can_take && go && armed;

  // Next-state section
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_LOAD;
      ST_LOAD:   state_d = ST_TERM_B;
      ST_TERM_B: state_d = ST_TERM_C;
      ST_TERM_C: state_d = ST_TERM_D;
      ST_TERM_D: state_d = ST_HOLD;
      ST_HOLD:   if (accept) state_d = ST_LOAD;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) mode_q <= mode;
    end
  end

  // Output section
  always_comb begin
    ctl          = '0;
    ctl.pick     = PICK_B;
    busy         = 1'b0;
    finished     = 1'b0;
    case (state_q)
      ST_LOAD: begin
        ctl.acc_we = 1'b1;
        ctl.take_a = 1'b1;
        busy       = 1'b1;
      end
      ST_TERM_B: begin
        ctl.acc_we   = 1'b1;
        ctl.pick     = PICK_B;
        ctl.subtract = mode_q;
        busy         = 1'b1;
      end
      ST_TERM_C: begin
        ctl.acc_we   = 1'b1;
        ctl.pick     = PICK_C;
        ctl.subtract = 1'b0;
        busy         = 1'b1;
      end
      ST_TERM_D: begin
        ctl.acc_we   = 1'b1;
        ctl.pick     = PICK_D;
        ctl.subtract = ~mode_q;
        busy         = 1'b1;
      end
      ST_HOLD: finished = 1'b1;
      default: ;
    endcase
  end

  // R7: the captured sign choice cannot move between busy cycles
  assert_mode_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

endmodule

// File: rtl/mas_datapath.sv
module mas_datapath
  import mas_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] c_in,
  input  logic [WIDTH-1:0] d_in,
  input  ctl_vec_t         ctl,
  output logic [WIDTH-1:0] acc
);

  localparam logic [WIDTH-1:0] ACC_CLEAR = '0;

  function automatic logic [WIDTH-1:0] step_value(
    input logic [WIDTH-1:0] base,
    input logic [WIDTH-1:0] term,
    input logic             minus
  );
    return minus ? (base - term) : (base + term);
  endfunction

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] operand;
  logic [WIDTH-1:0] alu_out;
  logic [WIDTH-1:0] acc_next;

  // Three-way operand selector
  always_comb begin
    case (ctl.pick)
      PICK_B:  operand = b_in;
      PICK_C:  operand = c_in;
      PICK_D:  operand = d_in;
      default: operand = b_in;
    endcase
  end

  assign alu_out = step_value(acc_q, operand, ctl.subtract);

  // Two-way accumulator input selector
  always_comb begin
    if (ctl.take_a) acc_next = a_in;
    else            acc_next = alu_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= ACC_CLEAR;
    else if (ctl.acc_we) acc_q <= acc_next;
  end

  assign acc = acc_q;

  // R10: a load cycle leaves operand a in the accumulator
  assert_load_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.acc_we && ctl.take_a) |-> (acc_q == $past(a_in)));

endmodule

// File: rtl/mode_arith_seq.sv
module mode_arith_seq
  import mas_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             mode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] result,
  output logic             finished
);

  ctl_vec_t ctl;
  logic     accept;
  logic     armed;
  logic     busy;

  mas_arm u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .accept (accept),
    .armed  (armed)
  );

  mas_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .mode     (mode),
    .armed    (armed),
    .ctl      (ctl),
    .accept   (accept),
    .busy     (busy),
    .finished (finished)
  );

  mas_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .a_in  (a),
    .b_in  (b),
    .c_in  (c),
    .d_in  (d),
    .ctl   (ctl),
    .acc   (result)
  );

  // R3: completion flag arrives five edges after acceptance
  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##5 finished);

  // R4: flag drops right after acceptance
  assert_done_low_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !finished);

  // R4: busy and finished never overlap
  assert_busy_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && finished));

  // R9: result frozen across consecutive finished cycles
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && $past(finished)) |-> $stable(result));

endmodule

// File: tb/mode_arith_seq_test.sv
`timescale 1ns/1ps
module mode_arith_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       go;
  logic       mode;
  logic [7:0] a, b, c, d;
  logic [7:0] result;
  logic       finished;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mode_arith_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode),
    .a(a), .b(b), .c(c), .d(d),
    .result(result), .finished(finished)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expect_final(input int ia, input int ib, input int ic,
                                      input int id, input bit m);
    int s;
    if (m) s = ia + ic + id + 256 - ib;
    else   s = ia + ib + ic + 256 - id;
    return s % 256;
  endfunction

  // Drives one request; flips mode after acceptance (R7) and traces partials (R10).
  task automatic run_op(input int ia, input int ib, input int ic, input int id,
                        input bit m);
    int part;
    @(negedge clk);
    a = ia[7:0]; b = ib[7:0]; c = ic[7:0]; d = id[7:0];
    mode = m; go = 1'b1;
    @(negedge clk);
    chk(finished, 0, "R4 busy after edge 1");
    mode = ~m;  // R7
    @(negedge clk);
    go = 1'b0;  // R5: go was high across two edges
    chk(result, ia % 256, "R10 load a");
    chk(finished, 0, "R4 busy after edge 2");
    @(negedge clk);
    part = m ? (ia + 256 - ib) % 256 : (ia + ib) % 256;
    chk(result, part, "R10 b term");
    @(negedge clk);
    part = (part + ic) % 256;
    chk(result, part, "R10 c term");
    chk(finished, 0, "R4 busy after edge 4");
    @(negedge clk);
    chk(finished, 1, "R3 done after edge 5");
    chk(result, expect_final(ia, ib, ic, id, m), m ? "R2 final" : "R1 final");
    @(negedge clk);
    chk(finished, 1, "R5 single run, still done");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    rst_n = 1'b0; go = 1'b0; mode = 1'b0;
    a = '0; b = '0; c = '0; d = '0;
    #5;
    chk(result, 0, "R8 reset result");
    chk(finished, 0, "R8 reset done");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // Corner operands
    run_op(0, 0, 0, 0, 0);
    run_op(255, 255, 255, 255, 0);
    run_op(255, 255, 255, 255, 1);
    run_op(1, 2, 255, 2, 0);
    run_op(254, 1, 1, 4, 1);
    run_op(0, 255, 0, 1, 1);
    run_op(128, 128, 128, 0, 0);

    // Sweep both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 160; i++) begin
        run_op((i * 37 + 5) % 256, (i * 91 + m * 13) % 256,
               (i * 53 + 200) % 256, (i * 11 + i * i) % 256, m[0]);
      end
    end

    // R6 / R9: go held high after completion
    @(negedge clk);
    a = 8'd10; b = 8'd20; c = 8'd30; d = 8'd5; mode = 1'b0; go = 1'b1;
    repeat (5) @(negedge clk);
    chk(finished, 1, "R6 first run done");
    r0 = expect_final(10, 20, 30, 5, 0);
    chk(result, r0, "R1 held-go run");
    repeat (4) @(negedge clk);
    chk(finished, 1, "R6 no retrigger while go high");
    chk(result, r0, "R6 result unchanged");
    a = 8'd99; b = 8'd77; c = 8'd3; d = 8'd200;
    repeat (3) @(negedge clk);
    chk(result, r0, "R9 operands change ignored");
    chk(finished, 1, "R9 still done");
    go = 1'b0;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    chk(finished, 0, "R6 re-armed request accepted");
    repeat (4) @(negedge clk);
    go = 1'b0;
    chk(finished, 1, "R3 re-armed run done");
    chk(result, expect_final(99, 77, 3, 200, 0), "R1 re-armed run");

    // R8: reset in mid-sequence
    @(negedge clk);
    a = 8'd40; b = 8'd1; c = 8'd2; d = 8'd3; mode = 1'b1; go = 1'b1;
    @(negedge clk); @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(result, 0, "R8 async clear mid-run");
    chk(finished, 0, "R8 done cleared mid-run");
    @(negedge clk);
    chk(result, 0, "R8 stays clear");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(finished, 0, "R8 idle after reset, no run");
    run_op(40, 1, 2, 3, 1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule